// File: doc/BRIEF.md
# ATA Alternate Control Register Unit

This block implements the two host-visible registers of the alternate control location in an ATA-style storage card's I/O task file. At one offset the host writes a control byte that holds a software reset line and an active-low interrupt mask. At the next offset up the host reads a status byte that shows the current head, the selected drive and the write gate, each active low.

The software reset is a level. It stays asserted for as long as the stored bit is 1 and it is released only when the host writes 0. It never disturbs the mask bit or any configuration state outside this block. The host interrupt is the raw card interrupt gated by the mask and passed through a register so that the output cannot glitch. The same mask also gates the interrupt bit that the card reports in its configuration status register.

The readback never drives bit 7 of the data bus. A floppy controller placed at the same address can therefore own that bit without contention.

Top module: `ata_alt_ctrl`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `softRst` and `hostIrq` are 0 and the stored mask bit is 0, which means interrupts are enabled.
- R2: A write at offset 0xE loads `softRst` from data bit 2 on the clock edge of the write. `softRst` then holds its value until the next write at offset 0xE, however many cycles pass.
- R3: A write at offset 0xE stores data bit 1 as the active-low interrupt mask. Data bits 7 to 3 and bit 0 have no effect on any output.
- R4: `hostIrq` equals `irqRaw` AND NOT mask, with both values sampled one clock edge earlier. A mask of 1 therefore keeps `hostIrq` at 0.
- R5: `cfgIntBit` equals `irqRaw` AND NOT mask within the same cycle, with no added latency.
- R6: A read at offset 0xF drives `hostRdataOe` = 0x7F. Bit 6 of the data is NOT `writeGate` and bits 5 to 2 are NOT `curHead`. Bit 7 of the data and bit 7 of the output enable are always 0.
- R7: In that readback, bit i for i in 0 to 1 is 0 only when `curDrive` equals i. Drive 0 therefore reads 2'b10 and drive 1 reads 2'b01.
- R8: A write at offset 0xF is ignored. `softRst`, the mask (seen through `cfgIntBit` and `hostIrq`) and every other output are unchanged by it.
- R9: A read at any offset other than 0xF, including 0xE, drives `hostRdataOe` = 0 and `hostRdata` = 0. The same holds whenever `hostRd` is low.
- R10: While `softRst` is 1 the mask bit keeps its value, and writes at offset 0xE still update both the mask and `softRst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, asynchronous, active low |
| hostAddr | input | 4 | Register offset within the task file |
| hostWr | input | 1 | Write strobe, one cycle per access |
| hostRd | input | 1 | Read strobe |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, valid in the cycle of `hostRd` |
| hostRdataOe | output | 8 | Per-bit output enable for the read data |
| curHead | input | 4 | Current head number, active high |
| curDrive | input | 1 | Index of the selected drive |
| writeGate | input | 1 | Write gate status, active high |
| irqRaw | input | 1 | Raw interrupt request from the card core |
| hostIrq | output | 1 | Masked, registered interrupt to the host |
| softRst | output | 1 | Level-held software reset to the controller |
| cfgIntBit | output | 1 | Masked interrupt bit for the configuration status register |

## Verification
The assertions assume that the host raises only one strobe per cycle, that the strobes are clean single-cycle levels, and that `curDrive` names one of the drives that exist. The stimulus meets these assumptions by design. Every access is a task that drives one strobe from one falling edge to the next. The status inputs change only while no read is in progress, and the drive index sweeps only 0 and 1.

// File: rtl/ata_alt_ctrl_pkg.sv
package ata_alt_ctrl_pkg;

  // Strobes from the address decoder to the register datapath.
  typedef struct packed {
    logic ctlWr;   // write to the control byte
    logic statRd;  // read of the drive status byte
  } regStrobes_t;

  // Control byte fields. The host software decodes these positions.
  localparam int CTL_SRST_BIT = 2;
  localparam int CTL_MASK_BIT = 1;

endpackage

// File: rtl/ata_alt_ctrl_decode.sv
module ata_alt_ctrl_decode
  import ata_alt_ctrl_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 4'hE,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'hF
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  output regStrobes_t       strb
);

  logic hitCtl;
  logic hitStat;

  always_comb begin
    hitCtl  = (hostAddr == CTL_OFS);
    hitStat = (hostAddr == STAT_OFS);
  end

  // The control byte is write-only here and the status byte is read-only.
  // Reads of the control byte and writes of the status byte raise no strobe.
  always_comb begin
    strb        = '0;
    strb.ctlWr  = hostWr & hitCtl;
    strb.statRd = hostRd & hitStat;
  end

endmodule

// File: rtl/ata_alt_ctrl_datapath.sv
module ata_alt_ctrl_datapath
  import ata_alt_ctrl_pkg::*;
#(
  parameter int HEAD_W     = 4,
  parameter int NUM_DRIVES = 2,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int DATA_W    = 2 + HEAD_W + NUM_DRIVES
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [HEAD_W-1:0] curHead,
  input  logic [DRV_W-1:0]  curDrive,
  input  logic              writeGate,
  input  logic              irqRaw,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] hostRdataOe,
  output logic              hostIrq,
  output logic              softRst,
  output logic              cfgIntBit
);

  localparam int WG_BIT   = DATA_W - 2;
  localparam int HEAD_LSB = NUM_DRIVES;

  logic srstQ;
  logic maskQ;
  logic irqQ;
  logic irqGated;
  logic [NUM_DRIVES-1:0] driveSelN;
  logic [DATA_W-1:0]     statByte;

  // Control byte storage. Only a hardware reset clears it.
  // The software reset leaves the mask alone.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srstQ <= 1'b0;
      maskQ <= 1'b0;
    end else if (strb.ctlWr) begin
      srstQ <= hostWdata[CTL_SRST_BIT];
      maskQ <= hostWdata[CTL_MASK_BIT];
    end
  end

  assign irqGated = irqRaw & ~maskQ;

  // Registered host interrupt, so the output cannot glitch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqGated;
  end

  assign hostIrq   = irqQ;
  assign softRst   = srstQ;
  assign cfgIntBit = irqGated;

  // One active-low select per drive.
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drvSel
    assign driveSelN[d] = (curDrive != DRV_W'(d));
  end

  always_comb begin
    statByte                                 = '0;
    statByte[NUM_DRIVES-1:0]                 = driveSelN;
    statByte[HEAD_LSB +: HEAD_W]             = ~curHead;
    statByte[WG_BIT]                         = ~writeGate;
  end

  // The top bit is never enabled, which leaves it free for another device.
  always_comb begin
    hostRdata   = '0;
    hostRdataOe = '0;
    if (strb.statRd) begin
      hostRdata   = statByte;
      hostRdataOe = {1'b0, {(DATA_W-1){1'b1}}};
    end
  end

  AST_SRST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctlWr |=> $stable(softRst)); // R2

  AST_SRST_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWr |=> (softRst == $past(hostWdata[CTL_SRST_BIT]))); // R2

  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |=> !hostIrq); // R4

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    !irqRaw |=> !hostIrq); // R4

  AST_CFG_INT_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    cfgIntBit |-> irqRaw); // R5

  AST_TOP_BIT_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdataOe[DATA_W-1] && !hostRdata[DATA_W-1]); // R6

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statRd |-> (hostRdataOe == '0 && hostRdata == '0)); // R9

  AST_ONE_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~driveSelN) == 1); // R7

endmodule

// File: rtl/ata_alt_ctrl.sv
module ata_alt_ctrl
  import ata_alt_ctrl_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                HEAD_W     = 4,
  parameter int                NUM_DRIVES = 2,
  parameter logic [ADDR_W-1:0] CTL_OFS    = 4'hE,
  parameter logic [ADDR_W-1:0] STAT_OFS   = 4'hF,
  localparam int DRV_W  = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int DATA_W = 2 + HEAD_W + NUM_DRIVES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] hostRdataOe,
  input  logic [HEAD_W-1:0] curHead,
  input  logic [DRV_W-1:0]  curDrive,
  input  logic              writeGate,
  input  logic              irqRaw,
  output logic              hostIrq,
  output logic              softRst,
  output logic              cfgIntBit
);

  regStrobes_t strb;

  ata_alt_ctrl_decode #(
    .ADDR_W  (ADDR_W),
    .CTL_OFS (CTL_OFS),
    .STAT_OFS(STAT_OFS)
  ) i_decode (
    .hostAddr(hostAddr),
    .hostWr  (hostWr),
    .hostRd  (hostRd),
    .strb    (strb)
  );

  ata_alt_ctrl_datapath #(
    .HEAD_W    (HEAD_W),
    .NUM_DRIVES(NUM_DRIVES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWdata  (hostWdata),
    .curHead    (curHead),
    .curDrive   (curDrive),
    .writeGate  (writeGate),
    .irqRaw     (irqRaw),
    .hostRdata  (hostRdata),
    .hostRdataOe(hostRdataOe),
    .hostIrq    (hostIrq),
    .softRst    (softRst),
    .cfgIntBit  (cfgIntBit)
  );

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == STAT_OFS) |=> $stable(softRst)); // R8

endmodule

// File: tb/test_ata_alt_ctrl.sv
module test_ata_alt_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] hostAddr;
  logic       hostWr;
  logic       hostRd;
  logic [7:0] hostWdata;
  logic [7:0] hostRdata;
  logic [7:0] hostRdataOe;
  logic [3:0] curHead;
  logic [0:0] curDrive;
  logic       writeGate;
  logic       irqRaw;
  logic       hostIrq;
  logic       softRst;
  logic       cfgIntBit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ata_alt_ctrl i_ata_alt_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRdataOe(hostRdataOe), .curHead(curHead), .curDrive(curDrive),
    .writeGate(writeGate), .irqRaw(irqRaw), .hostIrq(hostIrq),
    .softRst(softRst), .cfgIntBit(cfgIntBit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // A write lasts from one falling edge to the next. On return the
  // registered state has taken the write.
  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr  = a;
    hostWdata = d;
    hostWr    = 1'b1;
    @(negedge clk);
    hostWr    = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk);
    hostAddr = a;
    hostRd   = 1'b1;
    #1;
    d  = hostRdata;
    oe = hostRdataOe;
    hostRd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] oe;
    logic       expMask;
    rstN = 1'b0; hostAddr = '0; hostWr = 1'b0; hostRd = 1'b0; hostWdata = '0;
    curHead = '0; curDrive = '0; writeGate = 1'b0; irqRaw = 1'b1;

    repeat (3) @(negedge clk);
    chk("R1 softRst in reset", {7'b0, softRst}, 8'h00);
    chk("R1 hostIrq in reset", {7'b0, hostIrq}, 8'h00);
    chk("R1 mask clear in reset", {7'b0, cfgIntBit}, 8'h01);
    rstN = 1'b1;
    chk("R1 hostIrq at release", {7'b0, hostIrq}, 8'h00);
    @(negedge clk);
    chk("R4 default enabled", {7'b0, hostIrq}, 8'h01);

    // Sweep every control byte value: R2, R3, R4, R5.
    for (int w = 0; w < 256; w++) begin
      logic [7:0] wb;
      wb = 8'(w);
      irqRaw = wb[3] ^ wb[6] ^ wb[0];
      writeReg(4'hE, wb);
      expMask = wb[1];
      chk("R2 srst from bit 2", {7'b0, softRst}, {7'b0, wb[2]});
      chk("R5 cfgIntBit gated", {7'b0, cfgIntBit}, {7'b0, irqRaw & ~expMask});
      @(negedge clk);
      chk("R4 hostIrq gated", {7'b0, hostIrq}, {7'b0, irqRaw & ~expMask});
      chk("R3 other bits ignored", {6'b0, softRst, cfgIntBit},
          {6'b0, wb[2], irqRaw & ~expMask});
    end

    // R2: the level is held over idle cycles.
    irqRaw = 1'b1;
    writeReg(4'hE, 8'h04);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2 srst held", {7'b0, softRst}, 8'h01);
    end
    writeReg(4'hE, 8'h00);
    chk("R2 srst released", {7'b0, softRst}, 8'h00);

    // R10: the mask is kept and still writable during a soft reset.
    writeReg(4'hE, 8'h06);
    writeReg(4'hE, 8'h04);
    chk("R10 srst stays", {7'b0, softRst}, 8'h01);
    chk("R10 mask writable in srst", {7'b0, cfgIntBit}, 8'h01);
    writeReg(4'hE, 8'h06);
    repeat (4) @(negedge clk);
    chk("R10 mask kept in srst", {7'b0, cfgIntBit}, 8'h00);
    chk("R10 hostIrq masked in srst", {7'b0, hostIrq}, 8'h00);

    // R8: writes at the status offset change nothing.
    for (int v = 0; v < 8; v++) begin
      writeReg(4'hF, 8'(v * 37) ^ 8'hF9);
      @(negedge clk);
      chk("R8 srst unchanged", {7'b0, softRst}, 8'h01);
      chk("R8 mask unchanged", {6'b0, cfgIntBit, hostIrq}, 8'h00);
    end
    writeReg(4'hE, 8'h00);

    // R6, R7: sweep every head, drive and write gate combination.
    for (int h = 0; h < 16; h++) begin
      for (int d = 0; d < 2; d++) begin
        for (int g = 0; g < 2; g++) begin
          logic [7:0] exp;
          curHead = 4'(h); curDrive = 1'(d); writeGate = 1'(g);
          exp = 8'h00;
          exp = exp + 8'((1 - g) * 64) + 8'((15 - h) * 4) + ((d == 0) ? 8'd2 : 8'd1);
          readReg(4'hF, rd, oe);
          chk("R6 status data", rd, exp);
          chk("R6 status enables bit7 off", oe, 8'h7F);
          chk("R7 drive select", {6'b0, rd[1:0]}, (d == 0) ? 8'h02 : 8'h01);
        end
      end
    end

    // R9: every other offset returns nothing driven.
    for (int a = 0; a < 15; a++) begin
      readReg(4'(a), rd, oe);
      chk("R9 no drive off status", oe, 8'h00);
      chk("R9 zero data off status", rd, 8'h00);
    end
    @(negedge clk);
    hostAddr = 4'hF;
    #1;
    chk("R9 idle bus quiet", hostRdataOe, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule